// File: doc/BRIEF.md
# Configuration Load Sequencer

This block controls the loading of a programmable device's configuration memory. A load starts on power-on reset or when the active-low program request goes low, and a new program request may restart it at any moment. The sequencer first writes zero to every memory address. It then reads the mode pins once to choose master or slave operation and the transfer width. After that it takes a framed data stream.

A frame is a train of 32-bit words built from input beats, most significant bit first. Words are discarded until a bus-width detection pattern appears. A synchronisation word must follow. Next comes the device identification code, then a fixed number of payload words, which are written to memory in order. The last word is a CRC-32 over the payload. When the code and the CRC match, a one-cycle-per-step start-up runs: it releases the internal reset, optionally waits for clock lock, enables the output drivers, and raises done. A mismatch parks the block in an error state until the next program request.

Top module: `cfg_load_seq`

## Requirements
- R1: While `por_n` or `prog_n` is low, `done`, `io_en`, `core_rel` and `err` are low. Releasing `prog_n` starts a new load.
- R2: After each restart, every address 0..DEPTH-1 is written with zero, one per cycle, before any stream beat is taken.
- R3: `mode_i` is sampled once, after the clear. Bit 2 selects master (1) or slave (0), and `master_o` reports it. Bits 1:0 select the width: 00 = serial on `din[0]`, 01 = byte on `din[7:0]`, 10 = 16-bit on `din[15:0]`, 11 = serial.
- R4: Beats form 32-bit words, MSB first. Words are dropped until one equals the detection pattern 0x000000BB. The next word must be the sync word 0xAA995566; any other word returns the block to hunting for the pattern.
- R5: The word after sync must equal the parameter DEV_CODE. Any other value sets `err`.
- R6: The next DEPTH words are written to addresses 0, 1, ... DEPTH-1 in order.
- R7: The word after the payload must equal the CRC-32 of the payload (polynomial 0x04C11DB7, initial value 0xFFFFFFFF, MSB first, no final inversion). A mismatch sets `err` and leaves `core_rel` low.
- R8: A matching CRC word raises `core_rel` one cycle after its word completes. `io_en` follows at least one cycle later, and `done` exactly one cycle after `io_en`.
- R9: When WAIT_LOCK is 1, `io_en` does not rise until `lock_i` is high. When WAIT_LOCK is 0, lock is not consulted.
- R10: In the error state `done` stays low, `err` stays high, no memory write happens and further beats are ignored, until `prog_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| prog_n | input | 1 | Program request, synchronous, active low |
| mode_i | input | 3 | Mode pins: master select and width |
| din | input | 16 | Stream beat data |
| din_vld | input | 1 | Beat valid strobe |
| lock_i | input | 1 | Clock lock indication |
| mem_we | output | 1 | Configuration memory write enable |
| mem_addr | output | AW | Configuration memory address |
| mem_wdata | output | 32 | Configuration memory write data |
| master_o | output | 1 | Sampled master/slave selection |
| core_rel | output | 1 | Internal flip-flop reset released |
| io_en | output | 1 | Output drivers enabled |
| done | output | 1 | Load complete |
| err | output | 1 | Code or CRC mismatch |

## Verification
A beat counter or word register that is wrong misframes words. The sync word or device code then fails to match, so `err` rises or `done` never comes, and this shows within a few words of the error. A wrong memory index or CRC register shows up as wrong memory contents, or as an error raised exactly one cycle after the CRC word. A wrong start-up order shows in a single cycle as `io_en` or `done` rising out of turn.

// File: rtl/cfg_load_seq.sv
module cfg_load_seq #(
  parameter int          DEPTH     = 16,
  parameter logic [31:0] DEV_CODE  = 32'h0420_3093,
  parameter bit          WAIT_LOCK = 1'b1,
  localparam int         AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          prog_n,
  input  logic [2:0]    mode_i,
  input  logic [15:0]   din,
  input  logic          din_vld,
  input  logic          lock_i,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          master_o,
  output logic          core_rel,
  output logic          io_en,
  output logic          done,
  output logic          err
);
  localparam logic [31:0] WPAT = 32'h0000_00BB;
  localparam logic [31:0] SYNC = 32'hAA99_5566;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_MODE, S_DET, S_SYN, S_ID, S_LOAD, S_CRC,
    S_LCK, S_FIN, S_DONE, S_ERR
  } st_t;

  st_t         st;
  logic [1:0]  wsel;
  logic [31:0] sh, wd, crc, sh_nx;
  logic [4:0]  bc, bc_last;
  logic        wv, take;
  logic [AW-1:0] idx;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  assign take    = din_vld && (st inside {S_DET, S_SYN, S_ID, S_LOAD, S_CRC});
  assign bc_last = (wsel == 2'b01) ? 5'd3 : (wsel == 2'b10) ? 5'd1 : 5'd31;

  always_comb begin
    case (wsel)
      2'b01:   sh_nx = {sh[23:0], din[7:0]};
      2'b10:   sh_nx = {sh[15:0], din};
      default: sh_nx = {sh[30:0], din[0]};
    endcase
  end

  assign mem_we    = (st == S_CLR) || (st == S_LOAD && wv);
  assign mem_addr  = idx;
  assign mem_wdata = (st == S_LOAD) ? wd : 32'd0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sh <= '0; wd <= '0; wv <= 1'b0; bc <= '0;
    end else begin
      wv <= 1'b0;
      if (st == S_MODE) bc <= '0;
      else if (take) begin
        sh <= sh_nx;
        if (bc == bc_last) begin
          wd <= sh_nx; wv <= 1'b1; bc <= '0;
        end else bc <= bc + 5'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= S_IDLE; idx <= '0; wsel <= '0; master_o <= 1'b0; crc <= '1;
      core_rel <= 1'b0; io_en <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else if (!prog_n) begin
      st <= S_IDLE; idx <= '0;
      core_rel <= 1'b0; io_en <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin idx <= '0; st <= S_CLR; end
        S_CLR: begin
          idx <= idx + 1'b1;
          if (idx == LAST) st <= S_MODE;
        end
        S_MODE: begin
          wsel     <= (mode_i[1:0] == 2'b11) ? 2'b00 : mode_i[1:0];
          master_o <= mode_i[2];
          idx      <= '0;
          crc      <= '1;
          st       <= S_DET;
        end
        S_DET: if (wv && wd == WPAT) st <= S_SYN;
        S_SYN: if (wv) st <= (wd == SYNC) ? S_ID : S_DET;
        S_ID: if (wv) begin
          if (wd == DEV_CODE) st <= S_LOAD;
          else begin err <= 1'b1; st <= S_ERR; end
        end
        S_LOAD: if (wv) begin
          crc <= crc_step(crc, wd);
          idx <= idx + 1'b1;
          if (idx == LAST) st <= S_CRC;
        end
        S_CRC: if (wv) begin
          if (wd == crc) begin core_rel <= 1'b1; st <= S_LCK; end
          else begin err <= 1'b1; st <= S_ERR; end
        end
        S_LCK: if (!WAIT_LOCK || lock_i) begin io_en <= 1'b1; st <= S_FIN; end
        S_FIN: begin done <= 1'b1; st <= S_DONE; end
        default: ;
      endcase
    end
  end

  p_prog_clears_r1: assert property (@(posedge clk) disable iff (!por_n)
    !prog_n |=> (!done && !io_en && !core_rel && !err));
  p_oe_after_rel_r8: assert property (@(posedge clk) disable iff (!por_n)
    io_en |-> core_rel);
  p_done_after_oe_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(done) |-> $past(io_en));
  p_lock_gate_r9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(io_en) |-> (!WAIT_LOCK || $past(lock_i)));
  p_err_no_done_r10: assert property (@(posedge clk) disable iff (!por_n)
    err |-> (!done && !mem_we));
  p_no_write_when_done_r6: assert property (@(posedge clk) disable iff (!por_n)
    done |-> !mem_we);
endmodule

// File: tb/cfg_load_seq_bench.sv
`timescale 1ns/1ps
module cfg_load_seq_bench;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] DEV  = 32'h0420_3093;
  localparam logic [31:0] WPAT = 32'h0000_00BB;
  localparam logic [31:0] SYNC = 32'hAA99_5566;

  logic clk = 0, por_n = 0, prog_n = 1, din_vld = 0, lock_i = 0;
  logic [2:0] mode_i = 0;
  logic [15:0] din = 0;
  logic mem_we, master_o, core_rel, io_en, done, err;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic n_we, n_master, n_rel, n_oe, n_done, n_err;
  logic [AW-1:0] n_addr;
  logic [31:0] n_wdata;

  int errors = 0, checks = 0, wcount = 0;
  logic [31:0] mem [DEPTH];
  logic [31:0] pay [DEPTH];

  always #4 clk = ~clk;

  cfg_load_seq #(.DEPTH(DEPTH), .DEV_CODE(DEV), .WAIT_LOCK(1'b1)) u_cfg_load_seq (
    .clk, .por_n, .prog_n, .mode_i, .din, .din_vld, .lock_i,
    .mem_we, .mem_addr, .mem_wdata, .master_o, .core_rel, .io_en, .done, .err);

  cfg_load_seq #(.DEPTH(DEPTH), .DEV_CODE(DEV), .WAIT_LOCK(1'b0)) u_cfg_load_seq_nolock (
    .clk, .por_n, .prog_n, .mode_i, .din, .din_vld, .lock_i,
    .mem_we(n_we), .mem_addr(n_addr), .mem_wdata(n_wdata), .master_o(n_master),
    .core_rel(n_rel), .io_en(n_oe), .done(n_done), .err(n_err));

  always @(posedge clk) if (mem_we) begin mem[mem_addr] <= mem_wdata; wcount <= wcount + 1; end

  function automatic logic [31:0] crc32(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int i = 31; i >= 0; i--) r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? 32'h04C11DB7 : 32'h0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic beat(input logic [15:0] v);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    @(negedge clk); din = v; din_vld = 1;
    @(negedge clk); din_vld = 0; din = $urandom;
  endtask

  task automatic send(input logic [1:0] w, input logic [31:0] x);
    if (w == 2'b01)      for (int i = 3; i >= 0; i--) beat({8'h5A, x[i*8 +: 8]});
    else if (w == 2'b10) for (int i = 1; i >= 0; i--) beat(x[i*16 +: 16]);
    else                 for (int i = 31; i >= 0; i--) beat({15'h7FFF & $urandom, x[i]});
  endtask

  task automatic load(input logic [2:0] md, input int kind);
    logic [31:0] c, g;
    logic [1:0] w;
    int snap;
    w = (md[1:0] == 2'b11) ? 2'b00 : md[1:0];
    for (int a = 0; a < DEPTH; a++) mem[a] = 32'hDEADBEEF;
    @(negedge clk); mode_i = md; prog_n = 0;
    repeat (3) @(negedge clk);
    chk(!done && !io_en && !core_rel && !err, "R1 restart clears", {done, io_en, core_rel, err}, 0);
    prog_n = 1;
    repeat (DEPTH + 4) @(negedge clk);
    for (int a = 0; a < DEPTH; a++) chk(mem[a] == 0, "R2 clear", mem[a], 0);
    chk(master_o == md[2], "R3 master", master_o, md[2]);
    mode_i = ~md;
    repeat ($urandom_range(1, 3)) begin
      g = $urandom; if (g == WPAT) g = 1; send(w, g);
    end
    send(w, WPAT); send(w, 32'h1234_5678); send(w, WPAT); send(w, SYNC);
    send(w, (kind == 1) ? (DEV ^ 32'h10) : DEV);
    if (kind == 1) begin
      @(negedge clk);
      chk(err == 1, "R5 bad code", err, 1);
      snap = wcount;
      send(w, 32'h1); send(w, 32'h2); send(w, 32'h3);
      chk(wcount == snap, "R10 no writes in error", wcount - snap, 0);
      chk(err && !done, "R10 error held", {err, done}, 2);
      return;
    end
    c = 32'hFFFFFFFF;
    for (int a = 0; a < DEPTH; a++) begin pay[a] = $urandom; c = crc32(c, pay[a]); send(w, pay[a]); end
    send(w, (kind == 2) ? (c ^ 32'h8000_0000) : c);
    @(negedge clk);
    if (kind == 2) begin
      chk(err && !core_rel, "R7 bad crc", {err, core_rel}, 2);
      return;
    end
    chk(core_rel && !io_en && !done && !err, "R8 release first", {core_rel, io_en, done, err}, 4'b1000);
    repeat (4) @(negedge clk);
    chk(!io_en && !done, "R9 waits for lock", {io_en, done}, 0);
    chk(n_done, "R9 lock wait disabled", n_done, 1);
    lock_i = 1;
    @(negedge clk);
    chk(io_en && !done, "R8 outputs enabled", {io_en, done}, 2);
    @(negedge clk);
    chk(done && !err, "R8 done", {done, err}, 2);
    for (int a = 0; a < DEPTH; a++) chk(mem[a] == pay[a], "R6 payload", mem[a], pay[a]);
    lock_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(!done && !io_en && !core_rel && !err, "R1 reset state", {done, io_en, core_rel, err}, 0);
    por_n = 1;
    load(3'b100, 0);
    load(3'b001, 0);
    load(3'b110, 0);
    load(3'b011, 0);
    load(3'b001, 1);
    load(3'b010, 2);
    @(negedge clk); prog_n = 0; @(negedge clk); prog_n = 1;
    repeat (DEPTH + 4) @(negedge clk);
    send(2'b00, WPAT); send(2'b00, SYNC);
    load(3'b101, 0);
    chk(!err, "R4 framing after restart", err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule